// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Sequencer

This block decides, for each of twelve differential clock outputs, whether the output toggles or is parked with both legs low. Each output has three conditions. The first is its own active-low enable pin. The second is a register enable bit that can force the output off. The third is a shared power-good input, whose low level puts the whole device into power-down. The block drives one gate signal per output, and the output driver ANDs that gate with the clock.

The first rising edge of power-good captures two straps: the frequency-select level and the two-bit bandwidth/bypass mode code. Later rising edges only bring the device out of power-down. Software can replace the captured mode code with a register value.

Timing works in two clock domains. A free-running slow clock times the wake-up after power-down. The output clock times the enable delay and updates the gates on its falling edge, so a gate never cuts a clock high phase short.

Top module: `dif_gate_ctrl`

## Requirements
- R1: While the block is powered up and its register bit is 1, gate_o[i] follows the active-low pin oe_n_i[i]: a pin level of 0 turns the output on and 1 parks it.
- R2: A register bit reg_en_i[i] of 0 parks output i whatever the level of oe_n_i[i].
- R3: A change in an output's request shows on gate_o at the falling edge that follows the EN_DLY-th rising clk_i edge after the change (6 by default, inside a 4 to 10 clock window). gate_o changes only on falling edges.
- R4: A request change held for fewer than EN_DLY-2 output clocks is ignored, and the gate keeps its previous level.
- R5: After reset, every gate is 0, pll_en_o is 0, fsel_o is 0 and the mode reads low-bandwidth (bypass_o=0, hibw_o=0).
- R6: The first power-good rise captures fsel_strap_i into fsel_o and captures mode_strap_i as the mode code.
- R7: Later power-good rises do not capture the straps again. fsel_o and the mode outputs keep the values from the first capture.
- R8: While pwrgd_i is low, all gates go to 0 and pll_en_o goes to 0 within three slow-clock periods plus EN_DLY+3 output clocks.
- R9: Mode code 00 selects low-bandwidth PLL (hibw_o=0). Code 11 selects high-bandwidth PLL (hibw_o=1). Codes 01 and 10 select bypass (bypass_o=1, pll_en_o=0). Outside bypass, pll_en_o is 1 while the block is powered up.
- R10: When sw_mode_en_i is 1, the mode comes from sw_mode_i instead of the captured strap, using the R9 codes.
- R11: After pwrgd_i rises, the outputs stay parked for at least WAKE_TICKS slow-clock periods. They resume within WAKE_TICKS+4 slow-clock periods plus EN_DLY+3 output clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output-domain clock |
| slow_clk_i | input | 1 | Free-running slow clock for wake timing |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwrgd_i | input | 1 | Power-good; low requests power-down |
| fsel_strap_i | input | 1 | Frequency-select strap |
| mode_strap_i | input | 2 | Bandwidth/bypass strap code |
| oe_n_i | input | N_OUT | Per-output active-low enable pins |
| reg_en_i | input | N_OUT | Per-output register enable bits |
| sw_mode_en_i | input | 1 | Use the register mode instead of the strap |
| sw_mode_i | input | 2 | Register mode code |
| gate_o | output | N_OUT | Per-output clock gate (1 = toggle) |
| pll_en_o | output | 1 | PLL enable |
| bypass_o | output | 1 | Bypass mode active |
| hibw_o | output | 1 | High-bandwidth mode active |
| fsel_o | output | 1 | Captured frequency select |

## Verification
The assertions assume three things about the inputs. The straps are steady for at least two slow-clock edges around the first power-good rise. The register and mode inputs are quasi-static. The enable pins may change at any time, since they pass through synchronizers. The bench keeps to these assumptions. It changes straps only while power-good is settled, and it drives every other input half a clock away from the rising edge. It holds each level long enough that the expected outputs are fixed counts of clocks after the change.

// File: rtl/dif_gate_pkg.sv
package dif_gate_pkg;
  typedef enum logic [1:0] {
    MODE_LOBW = 2'b00,
    MODE_BYP  = 2'b01,
    MODE_HIBW = 2'b11
  } mode_e;

  // 10 has no meaning of its own and falls back to bypass
  function automatic mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'b00:   return MODE_LOBW;
      2'b11:   return MODE_HIBW;
      default: return MODE_BYP;
    endcase
  endfunction
endpackage

// File: rtl/dif_pwr_seq.sv
module dif_pwr_seq #(
  parameter int WAKE_TICKS = 16
) (
  input  logic       slow_clk_i,
  input  logic       rst_ni,
  input  logic       pwrgd_i,
  input  logic       fsel_i,
  input  logic [1:0] mode_i,
  output logic       run_o,
  output logic       fsel_o,
  output logic [1:0] mode_o
);
  localparam int CW = $clog2(WAKE_TICKS + 1);

  logic          pg_s1_q, pg_s2_q, pg_d_q, seen_q, run_q, fsel_q;
  logic [1:0]    mode_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge slow_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_s1_q <= 1'b0;
      pg_s2_q <= 1'b0;
      pg_d_q  <= 1'b0;
      seen_q  <= 1'b0;
      run_q   <= 1'b0;
      fsel_q  <= 1'b0;
      mode_q  <= 2'b00;
      cnt_q   <= '0;
    end else begin
      pg_s1_q <= pwrgd_i;
      pg_s2_q <= pg_s1_q;
      pg_d_q  <= pg_s2_q;
      if (pg_s2_q && !pg_d_q && !seen_q) begin
        seen_q <= 1'b1;
        fsel_q <= fsel_i;
        mode_q <= mode_i;
      end
      if (!pg_s2_q) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (!run_q) begin
        if (cnt_q == CW'(WAKE_TICKS - 1)) run_q <= 1'b1;
        else cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign run_o  = run_q;
  assign fsel_o = fsel_q;
  assign mode_o = mode_q;

  // R7
  strap_hold_chk: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    (seen_q && $past(seen_q)) |-> ($stable(fsel_q) && $stable(mode_q)));
  // R8
  pd_chk: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    !pg_s2_q |=> !run_q);
  // R11
  wake_chk: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(pg_s2_q));
endmodule

// File: rtl/dif_en_lane.sv
module dif_en_lane #(
  parameter int EN_DLY = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic gate_o
);
  // two synchronizer stages count toward the delay
  localparam int HOLD = EN_DLY - 3;
  localparam int CW   = $clog2(EN_DLY);

  logic          s1_q, s2_q, state_q, gate_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      s1_q <= req_i;
      s2_q <= s1_q;
      if (s2_q != state_q) begin
        if (cnt_q == CW'(HOLD)) begin
          state_q <= s2_q;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // update while clock is low: no runt pulses
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= state_q;
  end

  assign gate_o = gate_q;

  // R3
  state_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q) |-> $past(s2_q));
  // R4
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(s2_q) == $past(state_q)) |-> $stable(state_q));
endmodule

// File: rtl/dif_gate_ctrl.sv
module dif_gate_ctrl
  import dif_gate_pkg::*;
#(
  parameter int N_OUT      = 12,
  parameter int EN_DLY     = 6,
  parameter int WAKE_TICKS = 16
) (
  input  logic             clk_i,
  input  logic             slow_clk_i,
  input  logic             rst_ni,
  input  logic             pwrgd_i,
  input  logic             fsel_strap_i,
  input  logic [1:0]       mode_strap_i,
  input  logic [N_OUT-1:0] oe_n_i,
  input  logic [N_OUT-1:0] reg_en_i,
  input  logic             sw_mode_en_i,
  input  logic [1:0]       sw_mode_i,
  output logic [N_OUT-1:0] gate_o,
  output logic             pll_en_o,
  output logic             bypass_o,
  output logic             hibw_o,
  output logic             fsel_o
);
  logic       run_slow, run_s1_q, run_s2_q;
  logic [1:0] strap_mode;
  mode_e      mode;

  dif_pwr_seq #(.WAKE_TICKS(WAKE_TICKS)) u_pwr (
    .slow_clk_i (slow_clk_i),
    .rst_ni     (rst_ni),
    .pwrgd_i    (pwrgd_i),
    .fsel_i     (fsel_strap_i),
    .mode_i     (mode_strap_i),
    .run_o      (run_slow),
    .fsel_o     (fsel_o),
    .mode_o     (strap_mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_s1_q <= 1'b0;
      run_s2_q <= 1'b0;
    end else begin
      run_s1_q <= run_slow;
      run_s2_q <= run_s1_q;
    end
  end

  // strap and register mode are quasi-static
  assign mode     = decode_mode(sw_mode_en_i ? sw_mode_i : strap_mode);
  assign bypass_o = (mode == MODE_BYP);
  assign hibw_o   = (mode == MODE_HIBW);
  assign pll_en_o = run_s2_q && (mode != MODE_BYP);

  for (genvar g = 0; g < N_OUT; g++) begin : g_lane
    dif_en_lane #(.EN_DLY(EN_DLY)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (run_s2_q & reg_en_i[g] & ~oe_n_i[g]),
      .gate_o (gate_o[g])
    );
  end

  // R9
  pll_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_o |-> !pll_en_o);
  // R8
  pll_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_s2_q |-> !pll_en_o);
endmodule

// File: tb/dif_gate_ctrl_tb.sv
module dif_gate_ctrl_tb;
  localparam int N = 12;

  logic clk = 1'b0, slow_clk = 1'b0, rst_ni = 1'b0;
  logic pwrgd, fsel_s, sw_en;
  logic [1:0] mode_s, sw_mode;
  logic [N-1:0] oe_n, reg_en, gate;
  logic pll_en, byp, hibw, fsel;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always #200 slow_clk = ~slow_clk;

  dif_gate_ctrl u_dut (
    .clk_i(clk), .slow_clk_i(slow_clk), .rst_ni(rst_ni), .pwrgd_i(pwrgd),
    .fsel_strap_i(fsel_s), .mode_strap_i(mode_s), .oe_n_i(oe_n),
    .reg_en_i(reg_en), .sw_mode_en_i(sw_en), .sw_mode_i(sw_mode),
    .gate_o(gate), .pll_en_o(pll_en), .bypass_o(byp), .hibw_o(hibw),
    .fsel_o(fsel)
  );

  // {reg_en, oe_n, sw_en, sw_mode, gate, pll_en, bypass, hibw}; straps latched as hibw
  localparam logic [41:0] VEC [9] = '{
    {12'hFFF, 12'h000, 1'b0, 2'b00, 12'hFFF, 3'b101},  // R1
    {12'hFFF, 12'h0F0, 1'b0, 2'b00, 12'hF0F, 3'b101},  // R1
    {12'h00F, 12'h000, 1'b0, 2'b00, 12'h00F, 3'b101},  // R2
    {12'h0FF, 12'hF0F, 1'b0, 2'b00, 12'h0F0, 3'b101},  // R2
    {12'h555, 12'hAAA, 1'b0, 2'b00, 12'h555, 3'b101},  // R1
    {12'hFFF, 12'h000, 1'b1, 2'b01, 12'hFFF, 3'b010},  // R10
    {12'hFFF, 12'h000, 1'b1, 2'b00, 12'hFFF, 3'b100},  // R10
    {12'hFFF, 12'h000, 1'b1, 2'b10, 12'hFFF, 3'b010},  // R9
    {12'hFFF, 12'h000, 1'b0, 2'b00, 12'hFFF, 3'b101}   // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1ms;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    pwrgd = 0; fsel_s = 1; mode_s = 2'b11; oe_n = '0; reg_en = '1;
    sw_en = 0; sw_mode = 2'b00;
    #1000;
    @(negedge clk) rst_ni = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R5 gate", 32'(gate), 32'h0);
    chk("R5 pll_en", 32'(pll_en), 0);
    chk("R5 mode", 32'({byp, hibw}), 0);
    chk("R5 fsel", 32'(fsel), 0);

    @(negedge clk) #1 pwrgd = 1'b1;
    #5000;
    chk("R11 early", 32'(gate), 32'h0);
    #4000;
    chk("R11 resume", 32'(gate), 32'hFFF);
    chk("R6 fsel", 32'(fsel), 1);
    chk("R6 mode", 32'({pll_en, byp, hibw}), 32'b101);

    for (int i = 0; i < 9; i++) begin
      @(negedge clk) #1;
      {reg_en, oe_n, sw_en, sw_mode} = VEC[i][41:15];
      repeat (12) @(posedge clk); #1;
      chk("R1 R2 gate vector", 32'(gate), 32'(VEC[i][14:3]));
      chk("R9 R10 mode vector", 32'({pll_en, byp, hibw}), 32'(VEC[i][2:0]));
    end

    @(negedge clk) #1 begin fsel_s = 0; mode_s = 2'b01; pwrgd = 0; end
    #3000;
    chk("R8 gate", 32'(gate), 32'h0);
    chk("R8 pll_en", 32'(pll_en), 0);
    @(negedge clk) #1 pwrgd = 1'b1;
    #10000;
    chk("R7 fsel", 32'(fsel), 1);
    chk("R7 mode", 32'({pll_en, byp, hibw}), 32'b101);
    chk("R7 gate", 32'(gate), 32'hFFF);

    @(negedge clk) #1 oe_n[0] = 1'b1;
    repeat (6) @(posedge clk); #1;
    chk("R3 off before fall", 32'(gate[0]), 1);
    @(negedge clk) #1;
    chk("R3 off at fall", 32'(gate[0]), 0);
    @(negedge clk) #1 oe_n[0] = 1'b0;
    repeat (6) @(posedge clk); #1;
    chk("R3 on before fall", 32'(gate[0]), 0);
    @(negedge clk) #1;
    chk("R3 on at fall", 32'(gate[0]), 1);

    begin
      logic seen_low;
      seen_low = 1'b0;
      @(negedge clk) #1 oe_n[1] = 1'b1;
      repeat (3) @(negedge clk);
      #1 oe_n[1] = 1'b0;
      for (int k = 0; k < 15; k++) begin
        @(posedge clk); #1;
        if (!gate[1]) seen_low = 1'b1;
      end
      chk("R4 short pulse", 32'(seen_low), 0);
    end

    finish_run();
  end
endmodule